// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits between a simple request port and a four-bank double-data-rate DRAM. Each request carries a read/write flag, an auto-precharge flag and a flat address. The block splits the address into bank, row and column. It keeps the open row of every bank, and turns each request into the shortest legal command stream. A row hit goes straight to the column command. A closed bank is opened first. A row miss closes the old row, then opens the new one.

Minimum command spacings are enforced by one down-counter. A NOP is driven while a wait is pending. A free-running interval counter, derived from the clock frequency parameter, requests an auto refresh every 7.81 us. When a refresh is due and any bank is open, all banks are precharged first. A due refresh wins over a request that has not yet been accepted. Command, bank and address outputs are registered.

Top module: `ddr_cmd_seq`

## Requirements
- R1: `req_addr_i` is split as {bank, row, column}: the bank sits in the top BANK_W bits and the column in the low COL_W bits. ACTIVE drives the bank on `ba_o` and the row on `addr_o`.
- R2: A READ or WRITE to a bank with no open row is preceded by ACTIVE to that bank. ACTIVE is only issued to a closed bank.
- R3: A request that hits the open row of its bank issues READ or WRITE directly, with no PRECHARGE or ACTIVE.
- R4: A request that misses the open row issues PRECHARGE to that bank (`addr_o[10]`=0), then ACTIVE with the new row, then the access.
- R5: READ/WRITE carry the column on `addr_o[COL_W-1:0]` and the auto-precharge flag on `addr_o[10]`. With the flag set, the bank is then closed, so the next access to it starts with ACTIVE and has no PRECHARGE.
- R6: Minimum spacing from one non-NOP command to the next:
  - T_RCD after ACTIVE
  - T_RP after PRECHARGE
  - T_RFC after REFRESH
  - BURST_LEN/2 after READ/WRITE, or BURST_LEN/2+T_RP when auto precharge is set.
- R7: A refresh episode starts every REF_INT = CLK_MHZ*7.81 cycles (1562 at 200 MHz). If any bank is open, the episode is a precharge-all (PRECHARGE with `addr_o[10]`=1, `ba_o`=0) followed by REFRESH (`addr_o`=0, `ba_o`=0). REFRESH is issued only with all banks closed.
- R8: While a refresh is due, `req_ready_o` is low. The refresh commands come before any command of a request presented during that time.
- R9: Commands are encoded {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001. Out of reset `cmd_o` is NOP and `req_ready_o` is high.
- R10: A request is taken in the cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands change on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ap_i | input | 1 | Close the row after this burst |
| req_addr_i | input | BANK_W+ROW_W+COL_W | Flat address {bank, row, column} |
| req_ready_o | output | 1 | Request taken when high with req_valid_i |
| cmd_o | output | 4 | Registered {cs_n, ras_n, cas_n, we_n} |
| ba_o | output | BANK_W | Registered bank select |
| addr_o | output | ROW_W | Registered row / column / A10 address |

## Verification
The assertions check the following on every cycle:
- a non-NOP command appears only after the spacing counter ran out;
- ACTIVE leaves its bank marked open with the driven row;
- REFRESH never meets an open bank;
- a due refresh stays due until served;
- ready drops after each handshake.

The scoreboard adds what only scenarios can show: the exact command order for hits, misses, closed banks and auto precharge, the address split at its extreme values, and the minimum spacing of every command pair. Two further scenarios show the refresh period measured between episodes and that refresh is served before a request presented while it is due.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001
  } cmd_e;

  typedef enum logic {ST_IDLE, ST_ACC} seq_st_e;
endpackage

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       open_i,
  input  logic                       close_i,
  input  logic                       close_all_i,
  input  logic [BANK_W-1:0]          sel_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NB-1:0]              open_o,
  output logic [NB-1:0][ROW_W-1:0]   rows_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_sel;
    assign hit_sel = (sel_i == BANK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        rows_o[b] <= '0;
      end else if (close_all_i || (close_i && hit_sel)) begin
        open_o[b] <= 1'b0;
      end else if (open_i && hit_sel) begin
        open_o[b] <= 1'b1;
        rows_o[b] <= row_i;
      end
    end
  end
endmodule

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int REF_INT = 1562,
  localparam int CW     = $clog2(REF_INT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic due_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(REF_INT - 1);
      due_o <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= CW'(REF_INT - 1);
      else             cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0)  due_o <= 1'b1;
      else if (ack_i)   due_o <= 1'b0;
    end
  end

  AST_DUE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && !ack_i) |=> due_o); // R7
endmodule

// File: rtl/ddr_wait_cnt.sv
module ddr_wait_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BURST_LEN = 4,
  parameter int CLK_MHZ   = 200,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 14,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_ap_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);
  localparam int NB        = 1 << BANK_W;
  localparam int AP_BIT    = 10;
  localparam int REF_INT   = (CLK_MHZ * 781 + 50) / 100;
  localparam int BURST_CYC = BURST_LEN / 2;
  localparam int MAX_WAIT  = T_RFC + T_RP + BURST_CYC;
  localparam int WAIT_W    = $clog2(MAX_WAIT + 1);

  initial begin
    AST_BL_LEGAL: assert (BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)
      else $error("burst length"); // R6
    AST_COL_FITS: assert (COL_W <= AP_BIT && ROW_W > AP_BIT)
      else $error("column width"); // R5
  end

  seq_st_e st_q, st_d;
  logic              q_write, q_ap;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;

  logic [NB-1:0]            bank_open;
  logic [NB-1:0][ROW_W-1:0] bank_row;
  logic ref_due, ref_ack, wait_zero, wait_ld;
  logic [WAIT_W-1:0] wait_val;
  logic set_open, set_close, set_close_all, accept;
  cmd_e              cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ROW_W-1:0]  addr_d;
  logic              row_hit;

  ddr_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk_i, .rst_ni,
    .open_i(set_open), .close_i(set_close), .close_all_i(set_close_all),
    .sel_i(q_bank), .row_i(q_row),
    .open_o(bank_open), .rows_o(bank_row)
  );

  ddr_ref_timer #(.REF_INT(REF_INT)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .due_o(ref_due)
  );

  ddr_wait_cnt #(.W(WAIT_W)) u_wait (
    .clk_i, .rst_ni, .load_i(wait_ld), .val_i(wait_val), .zero_o(wait_zero)
  );

  assign req_ready_o = (st_q == ST_IDLE) && wait_zero && !ref_due;
  assign accept      = req_valid_i && req_ready_o;
  assign row_hit     = bank_open[q_bank] && (bank_row[q_bank] == q_row);

  always_comb begin
    st_d          = st_q;
    cmd_d         = CMD_NOP;
    ba_d          = '0;
    addr_d        = '0;
    wait_ld       = 1'b0;
    wait_val      = '0;
    set_open      = 1'b0;
    set_close     = 1'b0;
    set_close_all = 1'b0;
    ref_ack       = 1'b0;
    if (wait_zero) begin
      unique case (st_q)
        ST_IDLE: begin
          if (ref_due) begin
            wait_ld = 1'b1;
            if (|bank_open) begin
              cmd_d          = CMD_PRE;
              addr_d[AP_BIT] = 1'b1;
              set_close_all  = 1'b1;
              wait_val       = WAIT_W'(T_RP - 1);
            end else begin
              cmd_d    = CMD_REF;
              ref_ack  = 1'b1;
              wait_val = WAIT_W'(T_RFC - 1);
            end
          end else if (accept) begin
            st_d = ST_ACC;
          end
        end
        ST_ACC: begin
          ba_d    = q_bank;
          wait_ld = 1'b1;
          if (row_hit) begin
            cmd_d          = q_write ? CMD_WR : CMD_RD;
            addr_d         = ROW_W'(q_col);
            addr_d[AP_BIT] = q_ap;
            set_close      = q_ap;
            wait_val       = q_ap ? WAIT_W'(BURST_CYC + T_RP - 1) : WAIT_W'(BURST_CYC - 1);
            st_d           = ST_IDLE;
          end else if (bank_open[q_bank]) begin
            cmd_d     = CMD_PRE;
            set_close = 1'b1;
            wait_val  = WAIT_W'(T_RP - 1);
          end else begin
            cmd_d    = CMD_ACT;
            addr_d   = q_row;
            set_open = 1'b1;
            wait_val = WAIT_W'(T_RCD - 1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cmd_o   <= CMD_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      q_write <= 1'b0;
      q_ap    <= 1'b0;
      q_bank  <= '0;
      q_row   <= '0;
      q_col   <= '0;
    end else begin
      st_q   <= st_d;
      cmd_o  <= cmd_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
      if (accept) begin
        q_write <= req_write_i;
        q_ap    <= req_ap_i;
        {q_bank, q_row, q_col} <= req_addr_i;
      end
    end
  end

  AST_NOP_WHILE_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |-> $past(wait_zero)); // R6
  AST_ACT_OPENS_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |-> (bank_open[ba_o] && bank_row[ba_o] == addr_o)); // R2
  AST_REF_ALL_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (bank_open == '0)); // R7
  AST_ONE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
endmodule

// File: tb/tb_ddr_cmd_seq.sv
module tb_ddr_cmd_seq;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, BURST_LEN = 4;
  localparam int T_RCD = 3, T_RP = 3, T_RFC = 14, REF_INT = 1562;
  localparam int EW = 4 + BANK_W + ROW_W;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101,
                         WR = 4'b0100, PRE = 4'b0010, REF = 4'b0001;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ap = 0;
  logic [BANK_W+ROW_W+COL_W-1:0] req_addr = '0;
  logic req_ready;
  logic [3:0] cmd;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  ddr_cmd_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN),
    .CLK_MHZ(200), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_ap_i(req_ap), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .cmd_o(cmd), .ba_o(ba), .addr_o(addr));

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [EW-1:0] exp_q[$];
  bit m_open[4];
  logic [ROW_W-1:0] m_row[4];
  int last_cyc = -1000, min_gap = 0, pre_all_cyc = -1, ref_cnt = 0;
  int ref_cyc[2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input int b, input int a);
    exp_q.push_back({c, BANK_W'(b), ROW_W'(a)});
  endtask

  // driver: model the open rows, queue expected commands, then hand over the request
  task automatic req(input bit w, input int b, input int row, input int col, input bit ap);
    if (m_open[b] && m_row[b] == ROW_W'(row)) ;
    else begin
      if (m_open[b]) push(PRE, b, 0);
      push(ACT, b, row);
    end
    push(w ? WR : RD, b, (ap << 10) | col);
    m_open[b] = !ap;
    m_row[b]  = ROW_W'(row);
    req_valid = 1; req_write = w; req_ap = ap;
    req_addr  = {BANK_W'(b), ROW_W'(row), COL_W'(col)};
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(!req_ready, "R10 ready after accept", req_ready, 0);
  endtask

  task automatic expect_refresh();
    bit any = 0;
    for (int b = 0; b < 4; b++) begin
      any |= m_open[b];
      m_open[b] = 0;
    end
    if (any) push(PRE, 0, 1 << 10);
    push(REF, 0, 0);
  endtask

  // monitor: compare each non-NOP command with the queue, check spacing
  always @(negedge clk) if (rst_n && cmd != NOP) begin
    logic [EW-1:0] e;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : {NOP, {(EW-4){1'b0}}};
    chk({cmd, ba, addr} == e, "R1 R2 R3 R4 R5 R9 command order", {cmd, ba, addr}, e);
    chk(cyc - last_cyc >= min_gap, "R6 spacing", cyc - last_cyc, min_gap);
    last_cyc = cyc;
    case (cmd)
      ACT: min_gap = T_RCD;
      PRE: min_gap = T_RP;
      REF: min_gap = T_RFC;
      default: min_gap = BURST_LEN / 2 + (addr[10] ? T_RP : 0);
    endcase
    if (cmd == PRE && addr[10] && pre_all_cyc < 0) pre_all_cyc = cyc;
    if (cmd == REF) begin
      if (ref_cnt < 2) ref_cyc[ref_cnt] = cyc;
      ref_cnt++;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cmd == NOP, "R9 reset cmd", cmd, NOP);
    chk(req_ready == 1, "R9 reset ready", req_ready, 1);
    req(0, 0, 5, 8, 0);          // R2 closed bank
    req(0, 0, 5, 9, 0);          // R3 hit
    req(1, 1, 7, 3, 0);          // R2 write
    req(1, 0, 6, 1, 0);          // R4 miss
    req(0, 2, 100, 1023, 1);     // R5 auto precharge
    req(0, 2, 100, 4, 0);        // R5 reopen without precharge
    req(1, 3, 8191, 0, 0);       // R1 extreme row
    req(1, 3, 8191, 1023, 1);    // R1 R5 extreme column
    expect_refresh();            // R7 precharge-all then refresh
    while (ref_cnt < 1) @(negedge clk);
    chk(pre_all_cyc >= 0 && ref_cyc[0] - pre_all_cyc >= T_RP, "R7 precharge-all first",
        ref_cyc[0] - pre_all_cyc, T_RP);
    // R8: present a request in the cycle the next refresh becomes due
    while (cyc < pre_all_cyc + REF_INT - 1) @(negedge clk);
    chk(req_ready == 0, "R8 ready low while due", req_ready, 0);
    expect_refresh();
    req(0, 1, 42, 17, 0);
    chk(ref_cyc[1] - pre_all_cyc == REF_INT, "R7 refresh period",
        ref_cyc[1] - pre_all_cyc, REF_INT);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule